// File: doc/BRIEF.md
# Dual-Expiry Watchdog with Management Interrupt

This block is a countdown watchdog for a system controller. Software programs a period and then reloads the counter at regular intervals. If software stops reloading, the counter runs out and the block reaches its first expiry. At the first expiry the block sets a sticky timeout status bit and, if both interrupt enables allow it, raises a system-management interrupt. That interrupt gives firmware a chance to recover. If the status bit is still set when the counter runs out again, the block requests a reboot. The wait before a reboot is therefore a little over one period in the best case and about two periods in the worst case.

A clock-divider tick paces the countdown. Each expiry reloads the counter from the period register, so the counter keeps running. Software reaches the block through a simple register port: one write strobe, one shared address and combinational read data.

- Register `0x30` holds the interrupt enables.
- Register `0x60` holds the period.
- Register `0x64` holds the status.
- Register `0x68` holds the control.

A separate `kick` input reloads the counter.

A four-state machine tracks the expiry sequence:

| State | Transitions out |
|---|---|
| `S_ARMED` | An expiry moves it to `S_FLAGGED`. |
| `S_FLAGGED` | An expiry moves it to `S_FIRE`. A write-one-to-clear of the status bit moves it back to `S_ARMED`. If an expiry and a clear arrive in the same cycle, the expiry wins. |
| `S_FIRE` | Always moves to `S_HELD` after one cycle. |
| `S_HELD` | Never leaves. Only reset ends it. |

Top module: `dual_expiry_watchdog`

## Requirements
- R1: After reset, the outputs `smi`, `reboot_pulse` and `reboot_req` are 0. Reading `0x30` returns `0x00002001`. Reading `0x68` returns 0. Reading `0x64` returns 0. Reading `0x60` returns the parameter `DEFAULT_PERIOD`.
- R2: Let P be the period in `0x60` (low `CNT_W` bits) and D be `TICK_DIV`. The timeout bit (bit 3 of `0x64`) is set between P*D+1 and (P+1)*D clock cycles after the cycle in which `kick` was sampled high.
- R3: `smi` is high exactly when three bits are all 1: the timeout bit, bit 13 of `0x30` (watchdog interrupt enable) and bit 0 of `0x30` (global interrupt enable).
- R4: Writing `0x64` with bit 3 set clears the timeout bit. A write with bit 3 equal to 0 leaves the timeout bit unchanged.
- R5: An expiry that arrives while the timeout bit is set drives `reboot_pulse` high for exactly one cycle. It also sets `reboot_req`, which stays high until reset.
- R6: If the timeout bit is cleared before the next expiry, that next expiry only sets the timeout bit again and no reboot is requested.
- R7: A high `kick` reloads the counter with the period. It does not change the timeout bit.
- R8: While the halt bit (bit 11 of `0x68`) is set, the counter holds its value and no expiry occurs.
- R9: Clearing either interrupt enable bit in `0x30` suppresses `smi` but does not prevent a reboot on the second expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset, shared by reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| kick | input | 1 | Reloads the counter from the period register |
| smi | output | 1 | Management interrupt request (level) |
| reboot_pulse | output | 1 | One-cycle pulse on the second expiry |
| reboot_req | output | 1 | Latched reboot request |

## Verification
The bench measures the time from a reload to the first expiry. It checks that time against the window that the divider phase allows, which separates an off-by-one in the reload or the divider from correct counting.

The bench then drives several expiry patterns:
- A second expiry with the bit left set must produce a reboot.
- The same sequence with a clear in between must not produce one.
- A reload while the bit is set must keep the bit set.
- A halted counter must never expire.

Interrupt enable patterns of both-on, either-off and both-off show that each gating bit acts on `smi` alone while the reboot path still fires.

// File: rtl/dxw_pkg.sv
package dxw_pkg;

    typedef enum logic [1:0] {
        S_ARMED   = 2'd0,
        S_FLAGGED = 2'd1,
        S_FIRE    = 2'd2,
        S_HELD    = 2'd3
    } dxw_state_e;

    localparam logic [7:0] OFF_SMI_CTL = 8'h30;
    localparam logic [7:0] OFF_PERIOD  = 8'h60;
    localparam logic [7:0] OFF_STATUS  = 8'h64;
    localparam logic [7:0] OFF_CTRL    = 8'h68;

    localparam int BIT_GLB_SMI = 0;
    localparam int BIT_WDT_SMI = 13;
    localparam int BIT_TIMEOUT = 3;
    localparam int BIT_HALT    = 11;

endpackage

// File: rtl/dxw_prescaler.sv
module dxw_prescaler #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pc_q;

    generate
        if (TICK_DIV > 1) begin : g_div
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pc_q <= '0;
                end else if (pc_q == LAST) begin
                    pc_q <= '0;
                end else begin
                    pc_q <= pc_q + 1'b1;
                end
            end
            assign tick = (pc_q == LAST);
        end else begin : g_nodiv
            always_ff @(posedge clk) begin
                pc_q <= '0;
            end
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/dxw_countdown.sv
module dxw_countdown #(
    parameter int CNT_W          = 8,
    parameter int DEFAULT_PERIOD = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             kick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = tick && !halt && !kick && (cnt_q == '0);
    assign count  = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(DEFAULT_PERIOD);
        end else if (kick) begin
            cnt_q <= period;
        end else if (tick && !halt) begin
            if (cnt_q == '0) begin
                cnt_q <= period;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dxw_regs.sv
module dxw_regs
    import dxw_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    parameter int CNT_W          = 8,
    parameter int DEFAULT_PERIOD = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timeout_flag,
    output logic [DATA_W-1:0] rdata,
    output logic              wdt_smi_en,
    output logic              glb_smi_en,
    output logic              halt,
    output logic [CNT_W-1:0]  period,
    output logic              clear_req
);
    logic             wdt_en_q;
    logic             glb_en_q;
    logic             halt_q;
    logic [CNT_W-1:0] period_q;

    logic hit_smi, hit_period, hit_status, hit_ctrl;

    assign hit_smi    = (addr == ADDR_W'(OFF_SMI_CTL));
    assign hit_period = (addr == ADDR_W'(OFF_PERIOD));
    assign hit_status = (addr == ADDR_W'(OFF_STATUS));
    assign hit_ctrl   = (addr == ADDR_W'(OFF_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_en_q <= 1'b1;
            glb_en_q <= 1'b1;
            halt_q   <= 1'b0;
            period_q <= CNT_W'(DEFAULT_PERIOD);
        end else if (wr) begin
            if (hit_smi) begin
                wdt_en_q <= wdata[BIT_WDT_SMI];
                glb_en_q <= wdata[BIT_GLB_SMI];
            end
            if (hit_period) begin
                period_q <= wdata[CNT_W-1:0];
            end
            if (hit_ctrl) begin
                halt_q <= wdata[BIT_HALT];
            end
        end
    end

    assign clear_req  = wr && hit_status && wdata[BIT_TIMEOUT];
    assign wdt_smi_en = wdt_en_q;
    assign glb_smi_en = glb_en_q;
    assign halt       = halt_q;
    assign period     = period_q;

    always_comb begin
        rdata = '0;
        if (hit_smi) begin
            rdata[BIT_WDT_SMI] = wdt_en_q;
            rdata[BIT_GLB_SMI] = glb_en_q;
        end else if (hit_period) begin
            rdata[CNT_W-1:0] = period_q;
        end else if (hit_status) begin
            rdata[BIT_TIMEOUT] = timeout_flag;
        end else if (hit_ctrl) begin
            rdata[BIT_HALT] = halt_q;
        end
    end
endmodule

// File: rtl/dual_expiry_watchdog.sv
module dual_expiry_watchdog
    import dxw_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    parameter int CNT_W          = 8,
    parameter int TICK_DIV       = 1000,
    parameter int DEFAULT_PERIOD = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kick,
    output logic              smi,
    output logic              reboot_pulse,
    output logic              reboot_req
);
    dxw_state_e state_q, state_d;

    logic             tick;
    logic             expire;
    logic             halt_q;
    logic             wdt_smi_en, glb_smi_en;
    logic             clear_req;
    logic             timeout_flag;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;

    dxw_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dxw_countdown #(.CNT_W(CNT_W), .DEFAULT_PERIOD(DEFAULT_PERIOD)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .halt   (halt_q),
        .kick   (kick),
        .period (period_q),
        .count  (cnt_q),
        .expire (expire)
    );

    dxw_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CNT_W(CNT_W), .DEFAULT_PERIOD(DEFAULT_PERIOD)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (bus_wr),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .timeout_flag (timeout_flag),
        .rdata        (bus_rdata),
        .wdt_smi_en   (wdt_smi_en),
        .glb_smi_en   (glb_smi_en),
        .halt         (halt_q),
        .period       (period_q),
        .clear_req    (clear_req)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ARMED:   if (expire) state_d = S_FLAGGED;
            S_FLAGGED: begin
                if (expire)         state_d = S_FIRE;
                else if (clear_req) state_d = S_ARMED;
            end
            S_FIRE:    state_d = S_HELD;
            S_HELD:    state_d = S_HELD;
            default:   state_d = S_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        timeout_flag = 1'b0;
        reboot_pulse = 1'b0;
        reboot_req   = 1'b0;
        unique case (state_q)
            S_ARMED:   ;
            S_FLAGGED: timeout_flag = 1'b1;
            S_FIRE: begin
                timeout_flag = 1'b1;
                reboot_pulse = 1'b1;
                reboot_req   = 1'b1;
            end
            S_HELD: begin
                timeout_flag = 1'b1;
                reboot_req   = 1'b1;
            end
            default: ;
        endcase
        smi = timeout_flag && wdt_smi_en && glb_smi_en;
    end
endmodule

// File: rtl/dxw_chk.sv
module dxw_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kick,
    input logic             smi,
    input logic             reboot_pulse,
    input logic             reboot_req,
    input logic             timeout_flag,
    input logic             halt,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period
);
    // R5
    reboot_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> reboot_req);

    // R5
    reboot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_pulse |=> !reboot_pulse);

    // R5
    reboot_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reboot_req) |-> $past(timeout_flag));

    // R3
    smi_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> timeout_flag);

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick) |=> $stable(count));

    // R7
    kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == $past(period)));
endmodule

bind dual_expiry_watchdog dxw_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .kick         (kick),
    .smi          (smi),
    .reboot_pulse (reboot_pulse),
    .reboot_req   (reboot_req),
    .timeout_flag (timeout_flag),
    .halt         (halt_q),
    .count        (cnt_q),
    .period       (period_q)
);

// File: tb/sim_dual_expiry_watchdog.sv
module sim_dual_expiry_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 4;
    localparam int P0 = 6;
    localparam int P  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kick = 1'b0;
    logic        smi, reboot_pulse, reboot_req;

    int n_run = 0;
    int n_fail = 0;

    dual_expiry_watchdog #(
        .ADDR_W(8), .DATA_W(32), .CNT_W(8),
        .TICK_DIV(D), .DEFAULT_PERIOD(P0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kick(kick),
        .smi(smi), .reboot_pulse(reboot_pulse), .reboot_req(reboot_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; kick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_kick();
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    // waits until the timeout bit is set; returns cycles waited, or -1
    task automatic wait_flag(input int limit, output int n);
        logic [31:0] v;
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            rd(8'h64, v);
            if (v[3]) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 smi", {31'b0, smi}, 32'h0);
        check("R1 reboot_req", {31'b0, reboot_req}, 32'h0);
        check("R1 reboot_pulse", {31'b0, reboot_pulse}, 32'h0);
        rd(8'h30, v); check("R1 smi enables", v, 32'h0000_2001);
        rd(8'h68, v); check("R1 control", v, 32'h0);
        rd(8'h64, v); check("R1 status", v, 32'h0);
        rd(8'h60, v); check("R1 period", v, P0);
    endtask

    task automatic t_first_expiry();
        int n;
        do_reset();
        wr(8'h60, P);
        do_kick();
        wait_flag(200, n);
        // R2: expiry window after reload
        check("R2 window low", {31'b0, (n >= P*D+1)}, 32'h1);
        check("R2 window high", {31'b0, (n <= (P+1)*D)}, 32'h1);
        // R3: both enables on
        check("R3 smi both on", {31'b0, smi}, 32'h1);
        check("R2 no reboot yet", {31'b0, reboot_req}, 32'h0);
    endtask

    task automatic t_second_expiry();
        int pulses = 0;
        int n;
        logic seen_req = 1'b0;
        do_reset();
        wr(8'h60, P);
        do_kick();
        wait_flag(200, n);
        for (int i = 0; i < 3*(P+1)*D; i++) begin
            @(negedge clk);
            if (reboot_pulse) pulses++;
            if (reboot_req) seen_req = 1'b1;
        end
        // R5
        check("R5 pulse count", pulses, 32'd1);
        check("R5 req latched", {31'b0, reboot_req}, 32'h1);
        check("R5 seen", {31'b0, seen_req}, 32'h1);
        wr(8'h64, 32'h8);
        check("R5 req kept after clear write", {31'b0, reboot_req}, 32'h1);
    endtask

    task automatic t_clear();
        int n;
        logic [31:0] v;
        logic any_req = 1'b0;
        do_reset();
        wr(8'h60, P);
        do_kick();
        wait_flag(200, n);
        // R4: a write with bit 3 zero is ignored
        wr(8'h64, 32'hFFFF_FFF7);
        rd(8'h64, v); check("R4 zero write ignored", v, 32'h8);
        wr(8'h64, 32'h8);
        rd(8'h64, v); check("R4 w1c clears", v, 32'h0);
        check("R3 smi drops with flag", {31'b0, smi}, 32'h0);
        for (int i = 0; i < (P+1)*D + 2; i++) begin
            @(negedge clk);
            if (reboot_req) any_req = 1'b1;
        end
        // R6
        rd(8'h64, v); check("R6 flag set again", v, 32'h8);
        check("R6 no reboot", {31'b0, any_req}, 32'h0);
    endtask

    task automatic t_kick_keeps();
        int n;
        logic [31:0] v;
        do_reset();
        wr(8'h60, P);
        do_kick();
        wait_flag(200, n);
        do_kick();
        // R7
        rd(8'h64, v); check("R7 kick keeps flag", v, 32'h8);
        check("R7 no reboot right after kick", {31'b0, reboot_req}, 32'h0);
    endtask

    task automatic t_halt();
        int n;
        do_reset();
        wr(8'h60, P);
        wr(8'h68, 32'h800);
        do_kick();
        wait_flag(4*(P+1)*D, n);
        // R8
        check("R8 halted no expiry", n, 32'hFFFF_FFFF);
        wr(8'h68, 32'h0);
        wait_flag(200, n);
        check("R8 resumes after unhalt", {31'b0, (n > 0)}, 32'h1);
    endtask

    task automatic t_smi_gating();
        int n;
        logic seen = 1'b0;
        do_reset();
        wr(8'h60, P);
        wr(8'h30, 32'h0000_0001);
        do_kick();
        wait_flag(200, n);
        // R3 / R9
        check("R9 smi off with wdt enable 0", {31'b0, smi}, 32'h0);
        wr(8'h30, 32'h0000_2001);
        check("R3 smi on with both", {31'b0, smi}, 32'h1);
        wr(8'h30, 32'h0000_2000);
        check("R9 smi off with global 0", {31'b0, smi}, 32'h0);
        for (int i = 0; i < (P+2)*D; i++) begin
            @(negedge clk);
            if (smi) seen = 1'b1;
        end
        check("R9 reboot despite gating", {31'b0, reboot_req}, 32'h1);
        check("R9 smi stayed low", {31'b0, seen}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_first_expiry();
        t_second_expiry();
        t_clear();
        t_kick_keeps();
        t_halt();
        t_smi_gating();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule